// File: doc/BRIEF.md
# UART Transmit Queue with Empty-Interrupt Holdoff

This block buffers bytes that a CPU writes for a serial transmitter. Up to sixteen bytes sit in a first-in first-out store between the CPU write port and the transmit shift register. The shift register takes the oldest byte whenever it is ready for another character. The block also drives the transmit-empty interrupt. That line is asserted when the queue is empty and the interrupt is enabled.

A holdoff rule guards against a false empty interrupt. The case is a CPU that has just written a single byte into an empty queue and is still writing more. If that byte leaves for the shift register before a second byte arrives, the interrupt stays low for one character time. A character time is ten baud ticks. The rule stays armed until two bytes have been held in the queue at the same moment. After that, the next time the queue runs empty the interrupt rises at once.

Both data interfaces use valid/ready. On the CPU side a byte is taken on any cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly while the queue holds sixteen bytes. The CPU must hold its byte until it is accepted. On the shifter side `head_valid` is high whenever a byte is held, and `head_data` shows the oldest byte. A byte is removed on a cycle where `head_valid` and `head_ready` are both high. While `head_ready` is low, the head byte stays put.

Top module: `uart_txq`

## Requirements
- R1: The queue holds 16 bytes. While it holds 16, `wr_ready` is low and a byte offered on `wr_valid` is not stored. This includes a cycle in which a byte is removed.
- R2: On the cycle after a byte is removed from a full queue, `wr_ready` is high again.
- R3: `head_valid` is high exactly when at least one byte is held. `head_data` is the oldest byte held, and bytes leave in the order they were accepted. While `head_ready` is low, the head byte does not change.
- R4: When no holdoff is running, `irq` equals `ien` AND (queue empty). Out of reset the queue is empty, no holdoff is armed, and `irq` follows `ien`.
- R5: An accepted write into an empty queue makes `irq` low from the next cycle on.
- R6: Suppose the queue goes from one byte to empty while the holdoff is armed and `ien` is high. Then `irq` stays low through the cycles that follow until ten cycles with `baud_tick` high have passed, counted from the cycle after the emptying edge. `irq` rises on the cycle after the tenth such tick.
- R7: A write into an empty queue arms the holdoff. The holdoff is disarmed only once the queue holds two or more bytes. When the queue later empties while disarmed, `irq` rises on the next cycle.
- R8: An accepted write during a running holdoff cancels it. That byte was written into an empty queue, so it re-arms the rule, and its own drain starts a fresh ten-tick holdoff.
- R9: With `ien` low, `irq` is low in the same cycle and any running holdoff is dropped. Setting `ien` again while the queue is empty raises `irq` at once.
- R10: A write and a removal in the same cycle with one byte held leave one byte held. This counts neither as emptying nor as two bytes being held together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | CPU offers a byte |
| wr_ready | output | 1 | Queue can accept a byte (not full) |
| wr_data | input | 8 | Byte offered by the CPU |
| head_valid | output | 1 | A byte is held for the shifter |
| head_ready | input | 1 | Shifter takes the head byte |
| head_data | output | 8 | Oldest byte held |
| full | output | 1 | Queue holds 16 bytes |
| empty | output | 1 | Queue holds no bytes |
| ien | input | 1 | Transmit interrupt enable |
| baud_tick | input | 1 | One pulse per serial bit period |
| irq | output | 1 | Transmit-empty interrupt |

## Verification
The bench drives directed patterns, and each one separates two behaviours:
- A single byte drained before a refill shows the ten-tick holdoff; two bytes written before draining show the immediate interrupt.
- A refill during the holdoff exposes whether the write cancels the old count and restarts a new one.
- Writing past sixteen bytes while the shifter stalls, then draining, tests refusal, the one-cycle recovery of `wr_ready` and byte order.
- Toggling `ien` mid-holdoff and overlapping a write with a removal at one byte separate the enable path and the occupancy rule from the emptying path.
- A long random mix of writes, removals, ticks and enable changes is then compared with a behavioural model on every clock.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic {
    HO_IDLE = 1'b0,
    HO_WAIT = 1'b1
  } ho_state_e;

  localparam int unsigned TXQ_DEF_DEPTH      = 16;
  localparam int unsigned TXQ_DEF_CHAR_TICKS = 10;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_ptr_nx = wr_ptr + AW'(1);
      assign rd_ptr_nx = rd_ptr + AW'(1);
    end else begin : g_wrap
      assign wr_ptr_nx = (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      assign rd_ptr_nx = (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr_nx;
      if (pop)  rd_ptr <= rd_ptr_nx;
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
endmodule

// File: rtl/txq_holdoff.sv
module txq_holdoff #(
  parameter int unsigned CHAR_TICKS = 10,
  localparam int unsigned TW        = $clog2(CHAR_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ien,
  input  logic tick,
  input  logic arm_set,
  input  logic arm_clr,
  input  logic drain_last,
  input  logic cancel,
  output logic armed,
  output logic waiting
);
  import txq_pkg::*;

  localparam logic [TW-1:0] TICK_END = TW'(CHAR_TICKS - 1);

  ho_state_e     state;
  logic [TW-1:0] ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (arm_set) begin
      armed <= 1'b1;
    end else if (arm_clr) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HO_IDLE;
      ticks <= '0;
    end else if (!ien) begin
      state <= HO_IDLE;
      ticks <= '0;
    end else if (drain_last && armed) begin
      state <= HO_WAIT;
      ticks <= '0;
    end else if (state == HO_WAIT) begin
      if (cancel) begin
        state <= HO_IDLE;
        ticks <= '0;
      end else if (tick) begin
        if (ticks == TICK_END) begin
          state <= HO_IDLE;
          ticks <= '0;
        end else begin
          ticks <= ticks + TW'(1);
        end
      end
    end
  end

  assign waiting = (state == HO_WAIT);
endmodule

// File: rtl/uart_txq.sv
module uart_txq #(
  parameter int unsigned DEPTH      = txq_pkg::TXQ_DEF_DEPTH,
  parameter int unsigned DW         = 8,
  parameter int unsigned CHAR_TICKS = txq_pkg::TXQ_DEF_CHAR_TICKS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          head_valid,
  input  logic          head_ready,
  output logic [DW-1:0] head_data,
  output logic          full,
  output logic          empty,
  input  logic          ien,
  input  logic          baud_tick,
  output logic          irq
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C  = CW'(1);
  localparam logic [CW-1:0] TWO_C  = CW'(2);

  logic [CW-1:0] count, count_nx;
  logic          wr_fire, pop_fire, drain_last, ho_armed, ho_wait;

  assign full       = (count == FULL_C);
  assign empty      = (count == '0);
  assign wr_ready   = !full;
  assign head_valid = !empty;
  assign wr_fire    = wr_valid && wr_ready;
  assign pop_fire   = head_valid && head_ready;

  always_comb begin
    count_nx = count;
    if (wr_fire && !pop_fire) count_nx = count + ONE_C;
    if (pop_fire && !wr_fire) count_nx = count - ONE_C;
  end

  assign drain_last = pop_fire && !wr_fire && (count == ONE_C);

  txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_fire),
    .push_data (wr_data),
    .pop       (pop_fire),
    .head_data (head_data),
    .count     (count)
  );

  txq_holdoff #(.CHAR_TICKS(CHAR_TICKS)) u_ho (
    .clk        (clk),
    .rst_n      (rst_n),
    .ien        (ien),
    .tick       (baud_tick),
    .arm_set    (wr_fire && empty),
    .arm_clr    (count_nx >= TWO_C),
    .drain_last (drain_last),
    .cancel     (wr_fire),
    .armed      (ho_armed),
    .waiting    (ho_wait)
  );

  assign irq = ien && empty && !ho_wait;
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          head_valid,
  input logic          head_ready,
  input logic [7:0]    head_data,
  input logic          full,
  input logic          empty,
  input logic          ien,
  input logic          irq,
  input logic          armed,
  input logic [CW-1:0] count
);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !head_ready) |=> full);

  p_refill_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && head_ready) |=> (wr_ready && !full));

  p_head_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && !head_ready) |=> (head_valid && $stable(head_data)));

  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien && empty));

  p_first_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && wr_valid) |=> !irq);

  p_hold_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && count == ONE_C && head_ready && !wr_valid && armed) |=> !irq);

  p_fast_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && count == ONE_C && head_ready && !wr_valid && !armed) |=> (irq || !ien));

  p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);

  p_overlap_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == ONE_C && wr_valid && head_ready) |=> (head_valid && !empty));
endmodule

bind uart_txq txq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .head_valid (head_valid),
  .head_ready (head_ready),
  .head_data  (head_data),
  .full       (full),
  .empty      (empty),
  .ien        (ien),
  .irq        (irq),
  .armed      (ho_armed),
  .count      (count)
);

// File: tb/sim_uart_txq.sv
`timescale 1ns/1ps
module sim_uart_txq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, head_ready = 1'b0, ien = 1'b0, baud_tick = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, head_valid, full, empty, irq;
  logic [7:0] head_data;

  always #2.5 clk = ~clk;

  uart_txq u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .head_valid(head_valid), .head_ready(head_ready),
    .head_data(head_data), .full(full), .empty(empty), .ien(ien),
    .baud_tick(baud_tick), .irq(irq)
  );

  int    errors = 0, checks = 0;
  bit    done = 0;
  string phase = "R4 reset";

  // behavioural model
  byte unsigned q[$];
  bit  m_armed = 0, m_hold = 0;
  int  m_ticks = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  task automatic step(bit wv, byte unsigned wd, bit en, bit pop, bit tk);
    int  prev;
    bit  wf, pf;
    @(negedge clk);
    wr_valid = wv; wr_data = wd; ien = en; head_ready = pop; baud_tick = tk;
    #1;
    chk("wr_ready(R1)", wr_ready, q.size() < 16);
    chk("full(R1)", full, q.size() == 16);
    chk("head_valid(R3)", head_valid, q.size() > 0);
    chk("empty", empty, q.size() == 0);
    chk("irq", irq, en && q.size() == 0 && !m_hold);
    if (q.size() > 0) chk("head_data(R3)", head_data, q[0]);
    @(posedge clk);
    prev = q.size();
    wf = wv && prev < 16;
    pf = pop && prev > 0;
    if (pf) void'(q.pop_front());
    if (wf) q.push_back(wd);
    if (!en) begin
      m_hold = 0; m_ticks = 0;
    end else if (pf && !wf && prev == 1 && m_armed) begin
      m_hold = 1; m_ticks = 0;
    end else if (m_hold) begin
      if (wf) begin m_hold = 0; m_ticks = 0; end
      else if (tk) begin
        if (m_ticks == 9) begin m_hold = 0; m_ticks = 0; end
        else m_ticks++;
      end
    end
    if (wf && prev == 0) m_armed = 1;
    else if (q.size() >= 2) m_armed = 0;
  endtask

  task automatic idle(int n, bit en, bit tk);
    for (int i = 0; i < n; i++) step(0, 8'h00, en, 0, tk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R4 reset state";
    idle(3, 1, 0);
    idle(2, 0, 0);

    phase = "R5 R6 single byte holdoff";
    step(1, 8'hA1, 1, 0, 0);
    step(0, 8'h00, 1, 1, 0);
    for (int i = 0; i < 10; i++) begin step(0, 0, 1, 0, 1); idle(2, 1, 0); end
    idle(2, 1, 0);

    phase = "R7 two bytes disarm";
    step(1, 8'hB1, 1, 0, 0);
    step(1, 8'hB2, 1, 0, 0);
    step(0, 0, 1, 1, 0);
    step(0, 0, 1, 1, 0);
    idle(3, 1, 1);

    phase = "R8 write cancels holdoff";
    step(1, 8'hC1, 1, 0, 0);
    step(0, 0, 1, 1, 0);
    idle(4, 1, 1);
    step(1, 8'hC2, 1, 0, 1);
    step(0, 0, 1, 1, 0);
    idle(12, 1, 1);

    phase = "R1 R2 R3 fill refuse drain";
    for (int i = 0; i < 20; i++) step(1, 8'(8'h10 + i), 1, 0, 0);
    step(1, 8'hEE, 1, 1, 0);
    step(1, 8'h77, 1, 0, 0);
    step(1, 8'h78, 1, 0, 0);
    for (int i = 0; i < 18; i++) step(0, 0, 1, 1, 0);
    idle(2, 1, 0);

    phase = "R9 enable drop";
    step(1, 8'hD1, 1, 0, 0);
    step(0, 0, 1, 1, 0);
    idle(3, 1, 1);
    idle(2, 0, 1);
    idle(3, 1, 0);
    step(1, 8'hD2, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    idle(2, 1, 1);

    phase = "R10 overlap at one byte";
    step(1, 8'hE1, 1, 0, 0);
    step(1, 8'hE2, 1, 1, 0);
    step(1, 8'hE3, 1, 1, 0);
    step(0, 0, 1, 1, 0);
    for (int i = 0; i < 11; i++) step(0, 0, 1, 0, 1);
    idle(2, 1, 0);

    phase = "R1-mix random";
    for (int i = 0; i < 4000; i++)
      step(($urandom % 3) == 0, 8'($urandom), ($urandom % 16) != 0,
           ($urandom % 3) == 0, ($urandom % 3) == 0);

    finish_run();
  end
endmodule